// File: doc/BRIEF.md
# USB Token Handshake Responder

This block decides, one token at a time, how a low-level USB device function answers the host. It does not encode the line. It holds three kinds of state:
- a receive length register and the token stored with accepted data,
- the token most recently announced by SETUP or OUT,
- a double-buffer offset, plus one transmit length register for each IN endpoint slot.

The decoded token strobe and the data-packet strobe arrive from a receiver. From them the block produces, one cycle later, either a handshake PID to send or a request to transmit a buffered data packet from a given endpoint.

Firmware uses two write ports. It loads the transmit length registers with a byte count or a handshake PID. It releases the receive buffer by writing zero to the receive length register. While received data is still unprocessed, the block holds back every IN data reply. It rearms an endpoint with NAK at the moment its data is sent, and does not wait for the host acknowledgement. Data packets that are too short to carry a payload are acknowledged without being stored, so the buffer stays free for the next SETUP.

Top module: `usbr_responder`

## Requirements
- R1: After reset the receive length, stored receive token, stored current token and buffer offset are all zero. Every transmit length register holds the NAK PID 0x5A, and both reply strobes are low.
- R2: An IN token that arrives while the receive length, read as a signed byte, is 1 or more gets a handshake reply of NAK (0x5A). The addressed transmit register is left unchanged.
- R3: An IN token whose transmit register has bit 4 set gets that register value as a handshake reply, and the register keeps its value.
- R4: An IN token whose transmit register has bit 4 clear raises a data reply carrying that register value as the length and the endpoint number. The register becomes 0x5A in the same cycle.
- R5: IN endpoint 0 uses slot 0 and endpoint 3 uses slot 2. Every other nonzero endpoint uses slot 1. Firmware selects a slot with the same mapping.
- R6: The token PIDs are SETUP 0x2D, OUT 0xE1 and IN 0x69. A SETUP stores 0x2D as the current token. An OUT to endpoint 0 stores 0xE1, and an OUT to any nonzero endpoint stores 0xFF. Any other PID changes nothing.
- R7: A data packet that arrives while the current token is zero gets no reply and changes no register.
- R8: A data packet that arrives while the receive length is nonzero gets a NAK reply and is not stored.
- R9: A data packet with a length below 4 gets an ACK reply (0xD2) and is not stored. The buffer offset is not changed.
- R10: A data packet with a length of 4 or more, arriving while the buffer is free and a token is stored, is accepted. The block stores its length and the current token, sets the buffer offset to BUF_SIZE minus the old offset (0 or 11 by default), and replies ACK.
- R11: A firmware write loads the receive length with the written byte, and writing zero frees the buffer. A negative value counts as free for the IN check but as occupied for incoming data.
- R12: A reply appears on the clock edge after its strobe and lasts exactly one cycle. The handshake and data replies are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 8 | Token PID |
| tok_ep | input | 4 | Token endpoint number |
| dat_valid | input | 1 | Data packet received strobe |
| dat_len | input | 8 | Received packet length in bytes |
| fw_rx_wr | input | 1 | Firmware write to receive length |
| fw_rx_wdata | input | 8 | Value written to receive length |
| fw_tx_wr | input | 1 | Firmware write to a transmit length register |
| fw_tx_ep | input | 4 | Endpoint whose transmit register is written |
| fw_tx_wdata | input | 8 | Byte count or handshake PID |
| rsp_hs_valid | output | 1 | Handshake reply strobe |
| rsp_pid | output | 8 | Handshake PID to send |
| rsp_data_valid | output | 1 | Data packet send request strobe |
| rsp_len | output | 8 | Length of the data packet to send |
| rsp_ep | output | 4 | Endpoint whose buffer is sent |
| rx_len_o | output | 8 | Receive length register |
| rx_tok_o | output | 8 | Token stored with the accepted data |
| buf_off_o | output | 8 | Current receive buffer offset |

## Verification
The assertions check a fixed set of invariants on every cycle:
- A data reply only ever follows a free receive length.
- A busy buffer's length survives a data packet.
- An ignored packet leaves the receive state untouched.
- A slot that has sent data reads back NAK.
- The buffer offset is always one of its two legal values.
- The two reply strobes never fire together.

The bench scenarios cover the rest:
- The choice of reply for each ordering of token, firmware write and data packet.
- The token marker stored for OUT to a nonzero endpoint.
- The length-below-4 boundary.
- The endpoint-to-slot mapping.
- The treatment of a negative receive length.

// File: rtl/usbr_pkg.sv
package usbr_pkg;
  localparam int BYTE_W     = 8;
  localparam int EP_W       = 4;
  localparam int NUM_SLOTS  = 3;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SHORT_LEN  = 4;

  localparam logic [BYTE_W-1:0] PID_NAK    = 8'h5A;
  localparam logic [BYTE_W-1:0] PID_ACK    = 8'hD2;
  localparam logic [BYTE_W-1:0] PID_SETUP  = 8'h2D;
  localparam logic [BYTE_W-1:0] PID_OUT    = 8'hE1;
  localparam logic [BYTE_W-1:0] PID_IN     = 8'h69;
  localparam logic [BYTE_W-1:0] TOK_EPMARK = 8'hFF;
  localparam int HS_BIT = 4;

  function automatic logic [SLOT_W-1:0] ep_to_slot(input logic [EP_W-1:0] ep);
    if (ep == '0)                  return SLOT_W'(0);
    else if (ep == EP_W'(3))       return SLOT_W'(2);
    else                           return SLOT_W'(1);
  endfunction
endpackage

// File: rtl/usbr_rx_ctrl.sv
module usbr_rx_ctrl
  import usbr_pkg::*;
#(
  parameter int BUF_SIZE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_setup,
  input  logic              tok_out,
  input  logic              tok_ep_nz,
  input  logic              dat_valid,
  input  logic [BYTE_W-1:0] dat_len,
  input  logic              fw_wr,
  input  logic [BYTE_W-1:0] fw_wdata,
  output logic [BYTE_W-1:0] rx_len,
  output logic [BYTE_W-1:0] rx_tok,
  output logic [BYTE_W-1:0] buf_off,
  output logic              reply_valid,
  output logic [BYTE_W-1:0] reply_pid
);
  localparam logic [BYTE_W-1:0] BUF_SZ_B = BYTE_W'(BUF_SIZE);

  logic [BYTE_W-1:0] cur_tok_q, cur_tok_d;
  logic [BYTE_W-1:0] rx_len_q,  rx_len_d;
  logic [BYTE_W-1:0] rx_tok_q,  rx_tok_d;
  logic [BYTE_W-1:0] buf_off_q, buf_off_d;
  logic              cur_en, len_en, acc_en;
  logic              accept;

  always_comb begin
    cur_en      = tok_setup | tok_out;
    cur_tok_d   = tok_setup ? PID_SETUP : (tok_ep_nz ? TOK_EPMARK : PID_OUT);
    reply_valid = 1'b0;
    reply_pid   = PID_ACK;
    accept      = 1'b0;
    if (dat_valid && cur_tok_q != '0) begin
      reply_valid = 1'b1;
      if (rx_len_q != '0)                     reply_pid = PID_NAK;
      else if (dat_len < BYTE_W'(SHORT_LEN))  reply_pid = PID_ACK;
      else                                    accept    = 1'b1;
    end
    acc_en    = accept;
    rx_tok_d  = cur_tok_q;
    buf_off_d = BUF_SZ_B - buf_off_q;
    len_en    = accept | fw_wr;
    rx_len_d  = fw_wr ? fw_wdata : dat_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tok_q <= '0;
      rx_len_q  <= '0;
      rx_tok_q  <= '0;
      buf_off_q <= '0;
    end else begin
      if (cur_en) cur_tok_q <= cur_tok_d;
      if (len_en) rx_len_q  <= rx_len_d;
      if (acc_en) begin
        rx_tok_q  <= rx_tok_d;
        buf_off_q <= buf_off_d;
      end
    end
  end

  assign rx_len  = rx_len_q;
  assign rx_tok  = rx_tok_q;
  assign buf_off = buf_off_q;

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && rx_len_q != '0 && !fw_wr) |=> $stable(rx_len_q) && $stable(buf_off_q));

  assert_no_token_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && cur_tok_q == '0 && !fw_wr) |=>
      $stable(rx_len_q) && $stable(rx_tok_q) && $stable(buf_off_q));

  assert_offset_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_off_q == '0) || (buf_off_q == BUF_SZ_B));
endmodule

// File: rtl/usbr_tx_bank.sv
module usbr_tx_bank
  import usbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EP_W-1:0]   in_ep,
  input  logic [BYTE_W-1:0] rx_len,
  input  logic              fw_wr,
  input  logic [EP_W-1:0]   fw_ep,
  input  logic [BYTE_W-1:0] fw_wdata,
  output logic              hs_valid,
  output logic [BYTE_W-1:0] hs_pid,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_len
);
  logic [BYTE_W-1:0] txr_q [NUM_SLOTS];
  logic [BYTE_W-1:0] txr_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] txr_en;
  logic [NUM_SLOTS-1:0] clr;
  logic [SLOT_W-1:0] sel, fw_sel;
  logic [BYTE_W-1:0] cur;
  logic rx_busy;

  always_comb begin
    sel        = ep_to_slot(in_ep);
    fw_sel     = ep_to_slot(fw_ep);
    cur        = txr_q[sel];
    rx_busy    = $signed(rx_len) > 0;
    hs_valid   = 1'b0;
    hs_pid     = PID_NAK;
    data_valid = 1'b0;
    data_len   = cur;
    clr        = '0;
    if (in_valid) begin
      if (rx_busy) begin
        hs_valid = 1'b1;
      end else if (cur[HS_BIT]) begin
        hs_valid = 1'b1;
        hs_pid   = cur;
      end else begin
        data_valid = 1'b1;
        clr[sel]   = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic fw_hit;
    always_comb begin
      fw_hit    = fw_wr && (fw_sel == SLOT_W'(s));
      txr_en[s] = fw_hit | clr[s];
      txr_d[s]  = fw_hit ? fw_wdata : PID_NAK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         txr_q[s] <= PID_NAK;
      else if (txr_en[s]) txr_q[s] <= txr_d[s];
    end

    assert_rearm_nak_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && sel == SLOT_W'(s) && !fw_wr) |=> txr_q[s] == PID_NAK);
  end
endmodule

// File: rtl/usbr_responder.sv
module usbr_responder
  import usbr_pkg::*;
#(
  parameter int BUF_SIZE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [7:0]        tok_pid,
  input  logic [3:0]        tok_ep,
  input  logic              dat_valid,
  input  logic [7:0]        dat_len,
  input  logic              fw_rx_wr,
  input  logic [7:0]        fw_rx_wdata,
  input  logic              fw_tx_wr,
  input  logic [3:0]        fw_tx_ep,
  input  logic [7:0]        fw_tx_wdata,
  output logic              rsp_hs_valid,
  output logic [7:0]        rsp_pid,
  output logic              rsp_data_valid,
  output logic [7:0]        rsp_len,
  output logic [3:0]        rsp_ep,
  output logic [7:0]        rx_len_o,
  output logic [7:0]        rx_tok_o,
  output logic [7:0]        buf_off_o
);
  logic tok_setup, tok_out, tok_in;
  logic rx_rep_v, in_hs_v, in_dat_v;
  logic [BYTE_W-1:0] rx_rep_pid, in_hs_pid, in_dat_len;

  logic              hs_v_q, hs_v_d, dv_q, dv_d;
  logic [BYTE_W-1:0] pid_q, pid_d, len_q, len_d;
  logic [EP_W-1:0]   ep_q, ep_d;
  logic              pid_en, len_en;

  always_comb begin
    tok_setup = tok_valid && tok_pid == PID_SETUP;
    tok_out   = tok_valid && tok_pid == PID_OUT;
    tok_in    = tok_valid && tok_pid == PID_IN;
  end

  usbr_rx_ctrl #(.BUF_SIZE(BUF_SIZE)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .tok_setup(tok_setup), .tok_out(tok_out), .tok_ep_nz(tok_ep != '0),
    .dat_valid(dat_valid), .dat_len(dat_len),
    .fw_wr(fw_rx_wr), .fw_wdata(fw_rx_wdata),
    .rx_len(rx_len_o), .rx_tok(rx_tok_o), .buf_off(buf_off_o),
    .reply_valid(rx_rep_v), .reply_pid(rx_rep_pid)
  );

  usbr_tx_bank u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tok_in), .in_ep(tok_ep), .rx_len(rx_len_o),
    .fw_wr(fw_tx_wr), .fw_ep(fw_tx_ep), .fw_wdata(fw_tx_wdata),
    .hs_valid(in_hs_v), .hs_pid(in_hs_pid),
    .data_valid(in_dat_v), .data_len(in_dat_len)
  );

  always_comb begin
    hs_v_d = in_hs_v | rx_rep_v;
    pid_d  = in_hs_v ? in_hs_pid : rx_rep_pid;
    pid_en = hs_v_d;
    dv_d   = in_dat_v;
    len_d  = in_dat_len;
    ep_d   = tok_ep;
    len_en = in_dat_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_v_q <= 1'b0;
      dv_q   <= 1'b0;
      pid_q  <= '0;
      len_q  <= '0;
      ep_q   <= '0;
    end else begin
      hs_v_q <= hs_v_d;
      dv_q   <= dv_d;
      if (pid_en) pid_q <= pid_d;
      if (len_en) begin
        len_q <= len_d;
        ep_q  <= ep_d;
      end
    end
  end

  assign rsp_hs_valid   = hs_v_q;
  assign rsp_pid        = pid_q;
  assign rsp_data_valid = dv_q;
  assign rsp_len        = len_q;
  assign rsp_ep         = ep_q;

  assert_single_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hs_valid && rsp_data_valid));

  assert_data_only_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_data_valid |-> ($signed($past(rx_len_o)) < 1));
endmodule

// File: tb/usbr_responder_tb.sv
module usbr_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic tok_valid, dat_valid, fw_rx_wr, fw_tx_wr;
  logic [7:0] tok_pid, dat_len, fw_rx_wdata, fw_tx_wdata;
  logic [3:0] tok_ep, fw_tx_ep;
  logic rsp_hs_valid, rsp_data_valid;
  logic [7:0] rsp_pid, rsp_len, rx_len_o, rx_tok_o, buf_off_o;
  logic [3:0] rsp_ep;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usbr_responder dut_i (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_ep(tok_ep),
    .dat_valid(dat_valid), .dat_len(dat_len),
    .fw_rx_wr(fw_rx_wr), .fw_rx_wdata(fw_rx_wdata),
    .fw_tx_wr(fw_tx_wr), .fw_tx_ep(fw_tx_ep), .fw_tx_wdata(fw_tx_wdata),
    .rsp_hs_valid(rsp_hs_valid), .rsp_pid(rsp_pid),
    .rsp_data_valid(rsp_data_valid), .rsp_len(rsp_len), .rsp_ep(rsp_ep),
    .rx_len_o(rx_len_o), .rx_tok_o(rx_tok_o), .buf_off_o(buf_off_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tok_valid = 0; dat_valid = 0; fw_rx_wr = 0; fw_tx_wr = 0;
    tok_pid = 0; tok_ep = 0; dat_len = 0; fw_rx_wdata = 0; fw_tx_wdata = 0; fw_tx_ep = 0;
  endtask

  // drive on negedge, captured at next posedge, sampled at following negedge
  task automatic send_tok(input logic [7:0] pid, input logic [3:0] ep);
    @(negedge clk); tok_valid = 1; tok_pid = pid; tok_ep = ep;
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic send_dat(input logic [7:0] len);
    @(negedge clk); dat_valid = 1; dat_len = len;
    @(negedge clk); dat_valid = 0;
  endtask

  task automatic fw_rx(input logic [7:0] v);
    @(negedge clk); fw_rx_wr = 1; fw_rx_wdata = v;
    @(negedge clk); fw_rx_wr = 0;
  endtask

  task automatic fw_tx(input logic [3:0] ep, input logic [7:0] v);
    @(negedge clk); fw_tx_wr = 1; fw_tx_ep = ep; fw_tx_wdata = v;
    @(negedge clk); fw_tx_wr = 0;
  endtask

  task automatic expect_hs(input string tag, input int pid);
    chk({tag, " hs_valid"}, rsp_hs_valid, 1);
    chk({tag, " data_valid"}, rsp_data_valid, 0);
    chk({tag, " pid"}, rsp_pid, pid);
  endtask

  task automatic expect_data(input string tag, input int len, input int ep);
    chk({tag, " data_valid"}, rsp_data_valid, 1);
    chk({tag, " hs_valid"}, rsp_hs_valid, 0);
    chk({tag, " len"}, rsp_len, len);
    chk({tag, " ep"}, rsp_ep, ep);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " hs_valid"}, rsp_hs_valid, 0);
    chk({tag, " data_valid"}, rsp_data_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 rx_len", rx_len_o, 0);
    chk("R1 rx_tok", rx_tok_o, 0);
    chk("R1 buf_off", buf_off_o, 0);
    expect_none("R1 reply");
  endtask

  task automatic t_ignore_no_token();
    send_dat(8'd9);
    expect_none("R7 no token");
    chk("R7 rx_len", rx_len_o, 0);
    chk("R7 buf_off", buf_off_o, 0);
  endtask

  task automatic t_in_basic();
    send_tok(8'h69, 4'd0);
    expect_hs("R1 reset tx NAK", 8'h5A);
    @(negedge clk);
    expect_none("R12 one cycle pulse");
    fw_tx(4'd0, 8'd8);
    send_tok(8'h69, 4'd0);
    expect_data("R4 data", 8, 0);
    @(negedge clk);
    expect_none("R12 data pulse");
    send_tok(8'h69, 4'd0);
    expect_hs("R4 rearmed NAK", 8'h5A);
    fw_tx(4'd0, 8'hD2);
    send_tok(8'h69, 4'd0);
    expect_hs("R3 stored hs", 8'hD2);
    send_tok(8'h69, 4'd0);
    expect_hs("R3 hs kept", 8'hD2);
  endtask

  task automatic t_ep_map();
    fw_tx(4'd1, 8'd3);
    fw_tx(4'd3, 8'd5);
    send_tok(8'h69, 4'd3);
    expect_data("R5 ep3", 5, 3);
    send_tok(8'h69, 4'd1);
    expect_data("R5 ep1", 3, 1);
    fw_tx(4'd2, 8'd6);
    send_tok(8'h69, 4'd1);
    expect_data("R5 ep2 shares slot1", 6, 1);
    send_tok(8'h69, 4'd2);
    expect_hs("R5 slot1 rearmed", 8'h5A);
    send_tok(8'h69, 4'd0);
    expect_hs("R5 slot0 separate", 8'hD2);
  endtask

  task automatic t_accept_and_busy();
    send_tok(8'h2D, 4'd0);
    send_dat(8'd11);
    expect_hs("R10 accept ACK", 8'hD2);
    chk("R10 rx_len", rx_len_o, 11);
    chk("R6 setup token", rx_tok_o, 8'h2D);
    chk("R10 buf_off swap", buf_off_o, 11);
    send_dat(8'd8);
    expect_hs("R8 busy NAK", 8'h5A);
    chk("R8 rx_len kept", rx_len_o, 11);
    chk("R8 buf_off kept", buf_off_o, 11);
    fw_tx(4'd0, 8'd7);
    send_tok(8'h69, 4'd0);
    expect_hs("R2 IN held NAK", 8'h5A);
    fw_rx(8'd0);
    chk("R11 freed", rx_len_o, 0);
    send_tok(8'h69, 4'd0);
    expect_data("R2 tx kept after hold", 7, 0);
  endtask

  task automatic t_tokens();
    send_tok(8'hE1, 4'd2);
    send_dat(8'd6);
    expect_hs("R10 OUT accept", 8'hD2);
    chk("R6 nonzero ep marker", rx_tok_o, 8'hFF);
    chk("R10 buf_off back", buf_off_o, 0);
    fw_rx(8'd0);
    send_tok(8'hE1, 4'd0);
    send_tok(8'hA5, 4'd1);
    expect_none("R6 other pid");
    send_dat(8'd5);
    chk("R6 out ep0 token", rx_tok_o, 8'hE1);
    chk("R10 rx_len 5", rx_len_o, 5);
    chk("R10 buf_off 11", buf_off_o, 11);
  endtask

  task automatic t_short();
    fw_rx(8'd0);
    send_dat(8'd3);
    expect_hs("R9 short ACK", 8'hD2);
    chk("R9 not stored", rx_len_o, 0);
    chk("R9 buf_off kept", buf_off_o, 11);
    send_dat(8'd0);
    expect_hs("R9 zero len ACK", 8'hD2);
    chk("R9 zero not stored", rx_len_o, 0);
    send_dat(8'd4);
    expect_hs("R10 len4 ACK", 8'hD2);
    chk("R10 len4 stored", rx_len_o, 4);
    chk("R10 len4 swap", buf_off_o, 0);
  endtask

  task automatic t_negative();
    fw_rx(8'h80);
    chk("R11 write value", rx_len_o, 8'h80);
    fw_tx(4'd0, 8'd4);
    send_tok(8'h69, 4'd0);
    expect_data("R11 negative is free for IN", 4, 0);
    send_dat(8'd9);
    expect_hs("R11 negative busy for data", 8'h5A);
    chk("R11 rx_len kept", rx_len_o, 8'h80);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore_no_token();
    t_in_basic();
    t_ep_map();
    t_accept_and_busy();
    t_tokens();
    t_short();
    t_negative();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule